// File: doc/BRIEF.md
# Flash Write Sequencer

This block runs program and erase jobs on a NOR-style flash from the host side. A user hands it one request: a 2-bit operation code, a word address and a data word. The block then issues the unlock and command write cycles the flash needs on a simple synchronous memory bus. After the last command write it reads the target location again and again until bit 6 of the returned word stops changing. It then reads the location twice more to confirm the outcome, and finally signals completion with a pass or fail flag.

The second pair of reads guards against a read that lands at the same moment the flash finishes. A stop in bit 6 only counts as success if both follow-up reads return the expected value. A timeout based on twice the typical operation time ends a job whose bit 6 never settles. Bus accesses are spaced by a parameterised idle gap that stands in for the bus cycle time.

Top module: `nvm_wr_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `done`, `mem_wr` and `mem_rd` are 0. A request is taken on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle after `done`.
- R2: Op code 0 (program word) produces exactly four writes as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (request address, request data). Command addresses and data are zero-extended to the bus widths.
- R3: Op code 1 (sector erase) and op code 2 (block erase) each produce six writes. The first five are (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h). The sixth is (request address, 30h) for op 1 and (request address, 50h) for op 2.
- R4: Op code 3 (chip erase) produces the same five leading writes as R3, followed by (5555h, 10h).
- R5: `mem_wr` and `mem_rd` are never high together. Within one job, every bus access after the first is preceded by at least `RD_GAP` idle cycles. Read data must be presented on `mem_rdata` in the cycle after `mem_rd` is high.
- R6: After the last command write, every read goes to the request address. Polling ends when bit 6 of two consecutive polling reads has the same value.
- R7: Once polling ends, exactly two more reads of the location are made before `done`.
- R8: A confirm read is valid when bit 7 equals bit 7 of the written word (program), or when every bit is 1 (any erase). `err` is 0 only if both confirm reads are valid; otherwise `err` is 1.
- R9: If bit 6 is still changing after the polling phase has lasted at least 32·`CYC_PER_US` cycles (program), 32000·`CYC_PER_US` cycles (sector or block erase) or 128000·`CYC_PER_US` cycles (chip erase), the job ends with `err` = 1.
- R10: A request presented while `req_ready` is 0 is ignored: it causes no bus activity and does not change the job in progress.
- R11: `done` is high for exactly one cycle per job. `err` is meaningful only in that cycle and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with done |
| mem_wr | output | 1 | Bus write strobe |
| mem_rd | output | 1 | Bus read strobe |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data, valid the cycle after mem_rd |

## Verification
The bench builds the block with `CYC_PER_US` = 1, `RD_GAP` = 3, a 19-bit address and a 16-bit data word. The scale of 1 brings the program timeout down to 32 cycles, so a program that never settles times out within a few polling reads. The erase limit stays at 32000 cycles, so a slow erase of about 150 cycles must still pass, which shows that the limit is chosen per operation. The gap of 3 makes the spacing between accesses measurable. The behavioural responder can insert stale stable words, which exercises the false-completion case on the confirm reads.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } nvm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_GAP,
    ST_RD,
    ST_CAP,
    ST_FIN
  } nvm_st_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_POLL,
    PH_CONF
  } nvm_ph_e;

  localparam logic [14:0] UNLK_ADR_A = 15'h5555;
  localparam logic [14:0] UNLK_ADR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_1      = 8'hAA;
  localparam logic [7:0]  KEY_2      = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ERSU   = 8'h80;
  localparam logic [7:0]  CMD_SECT   = 8'h30;
  localparam logic [7:0]  CMD_BLK    = 8'h50;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;

endpackage

// File: rtl/nvm_seq_cmd.sv
module nvm_seq_cmd
  import nvm_seq_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  nvm_op_e       op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          is_last
);

  localparam logic [AW-1:0] ADR_A = AW'(UNLK_ADR_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLK_ADR_B);

  always_comb begin
    bus_addr = ADR_A;
    bus_data = '0;
    if (op == OP_PROG) begin
      is_last = (step == 3'd3);
      case (step)
        3'd0:    bus_data = DW'(KEY_1);
        3'd1:    begin bus_addr = ADR_B; bus_data = DW'(KEY_2); end
        3'd2:    bus_data = DW'(CMD_PROG);
        default: begin bus_addr = tgt_addr; bus_data = tgt_data; end
      endcase
    end else begin
      is_last = (step == 3'd5);
      case (step)
        3'd0:    bus_data = DW'(KEY_1);
        3'd1:    begin bus_addr = ADR_B; bus_data = DW'(KEY_2); end
        3'd2:    bus_data = DW'(CMD_ERSU);
        3'd3:    bus_data = DW'(KEY_1);
        3'd4:    begin bus_addr = ADR_B; bus_data = DW'(KEY_2); end
        default: begin
          case (op)
            OP_SECT: begin bus_addr = tgt_addr; bus_data = DW'(CMD_SECT); end
            OP_BLK:  begin bus_addr = tgt_addr; bus_data = DW'(CMD_BLK);  end
            default: bus_data = DW'(CMD_CHIP);
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/nvm_seq_judge.sv
module nvm_seq_judge #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd_data,
  input  logic          prev_b6,
  input  logic          is_prog,
  input  logic          exp_b7,
  output logic          b6_same,
  output logic          data_ok
);

  always_comb begin
    b6_same = (rd_data[6] == prev_b6);
    data_ok = is_prog ? (rd_data[7] == exp_b7) : (&rd_data);
  end

endmodule

// File: rtl/nvm_seq_tmo.sv
module nvm_seq_tmo #(
  parameter int CYC_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic is_prog,
  input  logic is_chip,
  output logic expired
);

  localparam int LIM_PROG  = 32 * CYC_PER_US;
  localparam int LIM_ERASE = 32000 * CYC_PER_US;
  localparam int LIM_CHIP  = 128000 * CYC_PER_US;
  localparam int TW        = $clog2(LIM_CHIP + 1);

  logic [TW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = is_prog ? TW'(LIM_PROG) : (is_chip ? TW'(LIM_CHIP) : TW'(LIM_ERASE));
    expired = (cnt_q >= lim);
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r9_clear_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !expired);

endmodule

// File: rtl/nvm_wr_seq.sv
module nvm_wr_seq
  import nvm_seq_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 50,
  parameter int RD_GAP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic          err,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int GW = (RD_GAP > 1) ? $clog2(RD_GAP) : 1;

  nvm_st_e       st_q, st_d;
  nvm_ph_e       ph_q, ph_d;
  nvm_op_e       op_q, op_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [2:0]    step_q, step_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          p6_q, p6_d, hp_q, hp_d, cf_q, cf_d, bad_q, bad_d, err_q, err_d;

  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_last, b6_same, data_ok, tmo_exp;

  nvm_seq_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .bus_addr(cmd_addr), .bus_data(cmd_data), .is_last(cmd_last)
  );

  nvm_seq_judge #(.DW(DW)) u_judge (
    .rd_data(mem_rdata), .prev_b6(p6_q), .is_prog(op_q == OP_PROG),
    .exp_b7(data_q[7]), .b6_same(b6_same), .data_ok(data_ok)
  );

  nvm_seq_tmo #(.CYC_PER_US(CYC_PER_US)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(st_q == ST_IDLE), .run(ph_q == PH_POLL),
    .is_prog(op_q == OP_PROG), .is_chip(op_q == OP_CHIP), .expired(tmo_exp)
  );

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    done      = (st_q == ST_FIN);
    err       = done & err_q;
    mem_wr    = (st_q == ST_WR);
    mem_rd    = (st_q == ST_RD);
    mem_addr  = mem_wr ? cmd_addr : addr_q;
    mem_wdata = mem_wr ? cmd_data : '0;
  end

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  op_d = op_q;  addr_d = addr_q;  data_d = data_q;
    step_d = step_q;  gap_d = gap_q;  p6_d = p6_q;  hp_d = hp_q;
    cf_d = cf_q;  bad_d = bad_q;  err_d = err_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        op_d = nvm_op_e'(req_op);  addr_d = req_addr;  data_d = req_data;
        step_d = '0;  ph_d = PH_CMD;  hp_d = 1'b0;  cf_d = 1'b0;
        bad_d = 1'b0;  err_d = 1'b0;  st_d = ST_WR;
      end
      ST_WR: begin
        step_d = step_q + 1'b1;
        if (cmd_last) ph_d = PH_POLL;
        gap_d = GW'(RD_GAP - 1);
        st_d  = ST_GAP;
      end
      ST_GAP: begin
        if (gap_q == '0) st_d = (ph_q == PH_CMD) ? ST_WR : ST_RD;
        else             gap_d = gap_q - 1'b1;
      end
      ST_RD: st_d = ST_CAP;
      ST_CAP: begin
        gap_d = GW'(RD_GAP - 1);
        st_d  = ST_GAP;
        if (ph_q == PH_POLL) begin
          p6_d = mem_rdata[6];
          hp_d = 1'b1;
          if (hp_q && b6_same) ph_d = PH_CONF;
          else if (tmo_exp) begin err_d = 1'b1; st_d = ST_FIN; end
        end else begin
          bad_d = bad_q | ~data_ok;
          cf_d  = 1'b1;
          if (cf_q) begin err_d = bad_q | ~data_ok; st_d = ST_FIN; end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_CMD;  op_q <= OP_PROG;
      addr_q <= '0;  data_q <= '0;  step_q <= '0;  gap_q <= '0;
      p6_q <= 1'b0;  hp_q <= 1'b0;  cf_q <= 1'b0;  bad_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  op_q <= op_d;
      addr_q <= addr_d;  data_q <= data_d;  step_q <= step_d;  gap_q <= gap_d;
      p6_q <= p6_d;  hp_q <= hp_d;  cf_q <= cf_d;  bad_q <= bad_d;  err_q <= err_d;
    end
  end

  a_r1_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_first_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && step_q == 3'd0) |-> (mem_addr == AW'(15'h5555) && mem_wdata == DW'(8'hAA)));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  a_r6_poll_target: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr == addr_q && ph_q != PH_CMD));

  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_nvm_wr_seq.sv
module sim_nvm_wr_seq;

  localparam int AW = 19;
  localparam int DW = 16;
  localparam int CPU = 1;
  localparam int GAP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          done, err, mem_wr, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  nvm_wr_seq #(.AW(AW), .DW(DW), .CYC_PER_US(CPU), .RD_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .err(err), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0, cyc = 0, ndone = 0;
  logic [AW+DW-1:0] wq[$];
  bit   res_q[$];
  bit   tmo_q[$];
  string tag_q[$];
  string cur_tag = "R2";
  logic [AW-1:0] cur_addr = '0;
  int last_acc = -1, last_wr = 0;
  bit prev_done = 1'b0;

  int busy_left = 0, mid_left = 0;
  logic [DW-1:0] mid_val = '0, fin_val = '0;
  bit rsp_b7 = 1'b0, tog = 1'b0, havep = 1'b0, p6 = 1'b0, stopped = 1'b0;
  int after = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic [DW-1:0] v;
    cyc++;
    if (rst_n) begin
      if (mem_wr || mem_rd) begin
        if (last_acc >= 0) chk(cyc - last_acc - 1 >= GAP, "R5 gap", cyc - last_acc - 1, GAP);
        chk(!(mem_wr && mem_rd), "R5 overlap", {mem_wr, mem_rd}, 0);
        last_acc = cyc;
      end
      if (mem_wr) begin
        if (wq.size() == 0) chk(0, "R10 stray write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = wq.pop_front();
          chk({mem_addr, mem_wdata} == e, cur_tag, {mem_addr, mem_wdata}, e);
        end
        last_wr = cyc;
      end
      if (mem_rd) begin
        chk(mem_addr == cur_addr, "R6 read addr", mem_addr, cur_addr);
        if (busy_left > 0) begin
          v = '0; v[7] = rsp_b7; v[6] = tog; tog = ~tog; busy_left--;
        end else if (mid_left > 0) begin
          v = mid_val; mid_left--;
        end else v = fin_val;
        mem_rdata = v;
        if (!stopped && havep && v[6] == p6) begin stopped = 1'b1; after = 0; end
        else if (stopped) after++;
        p6 = v[6]; havep = 1'b1;
      end
      if (done) begin
        chk(!prev_done, "R11 done width", 1, 0);
        if (res_q.size() == 0) chk(0, "R11 unexpected done", 1, 0);
        else begin
          bit xe, xt;
          string t;
          xe = res_q.pop_front(); xt = tmo_q.pop_front(); t = tag_q.pop_front();
          chk(err == xe, t, err, xe);
          if (xt) chk(cyc - last_wr >= 32 * CPU, "R9 timeout not early", cyc - last_wr, 32 * CPU);
          else    chk(after == 2, "R7 confirm reads", after, 2);
        end
        chk(wq.size() == 0, "R2 write count", wq.size(), 0);
        ndone++;
      end else chk(!err, "R11 err idle", err, 0);
      prev_done = done;
    end
  end

  task automatic push_w(input logic [14:0] a, input logic [7:0] d);
    wq.push_back({AW'(a), DW'(d)});
  endtask

  task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int nbusy, input int nmid, input logic [DW-1:0] vmid,
                         input logic [DW-1:0] vfin, input bit xerr, input bit xtmo,
                         input bit poke, input string wtag, input string rtag);
    int n0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    push_w(15'h5555, 8'hAA); push_w(15'h2AAA, 8'h55);
    if (op == 2'd0) begin
      push_w(15'h5555, 8'hA0); wq.push_back({a, d});
    end else begin
      push_w(15'h5555, 8'h80); push_w(15'h5555, 8'hAA); push_w(15'h2AAA, 8'h55);
      case (op)
        2'd1: wq.push_back({a, DW'(8'h30)});
        2'd2: wq.push_back({a, DW'(8'h50)});
        default: push_w(15'h5555, 8'h10);
      endcase
    end
    res_q.push_back(xerr); tmo_q.push_back(xtmo); tag_q.push_back(rtag);
    cur_tag = wtag; cur_addr = a; last_acc = -1;
    busy_left = nbusy; mid_left = nmid; mid_val = vmid; fin_val = vfin;
    rsp_b7 = (op == 2'd0) ? ~d[7] : 1'b0;
    tog = 1'b0; havep = 1'b0; stopped = 1'b0; after = 0;
    n0 = ndone;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h0_0042; req_data = 16'h1111;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    do @(negedge clk); while (ndone == n0);
    @(negedge clk);
    chk(req_ready, "R1 ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R1 reset bus", {mem_wr, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 program, clean finish
    run_req(2'd0, 19'h4_1234, 16'hBEEF, 5, 0, '0, 16'hBEEF, 1'b0, 1'b0, 1'b0, "R2 prog write", "R7 prog pass");
    // R3 sector erase
    run_req(2'd1, 19'h7_A800, 16'h0000, 8, 0, '0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 sector write", "R7 sector pass");
    // R3 block erase
    run_req(2'd2, 19'h3_8000, 16'h0000, 4, 0, '0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 block write", "R7 block pass");
    // R4 chip erase with R10 stray request during the job
    run_req(2'd3, 19'h0_0100, 16'h0000, 6, 0, '0, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R4 chip write", "R10 chip pass");
    // R8 program: stale stable word with wrong bit 7 on confirm reads
    run_req(2'd0, 19'h1_0001, 16'h1234, 3, 10, 16'h0080, 16'h1234, 1'b1, 1'b0, 1'b0, "R2 prog write", "R8 prog race reject");
    // R8 erase: settled word not all ones
    run_req(2'd1, 19'h0_0800, 16'h0000, 4, 0, '0, 16'hFFFE, 1'b1, 1'b0, 1'b0, "R3 sector write", "R8 erase not blank");
    // R8 program: only bit 7 decides validity
    run_req(2'd0, 19'h2_2222, 16'h80FF, 5, 0, '0, 16'h0080, 1'b0, 1'b0, 1'b0, "R2 prog write", "R8 prog bit7 only");
    // R9 program never settles: timeout
    run_req(2'd0, 19'h5_5555, 16'h00AA, 1000000, 0, '0, 16'h00AA, 1'b1, 1'b1, 1'b0, "R2 prog write", "R9 prog timeout");
    // R9 erase busy longer than the program limit still passes
    run_req(2'd2, 19'h6_0000, 16'h0000, 25, 0, '0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 block write", "R9 erase long pass");
    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule